// File: doc/BRIEF.md
# Fixed-Priority Parameterized Crossbar Switch

This block is a purely combinational switch between a set of requesting ports (masters) and a set of target ports (slaves). The two counts are independent parameters. Each master presents a request vector with one bit per slave. A master normally sets at most one bit, naming the slave it wants. Every slave column is arbitrated on its own: the lowest-numbered master that requests that slave wins it. The winner's address and data then appear on that slave's outputs.

Because each column is arbitrated separately, several masters can be served in the same cycle, provided each targets a different slave. The reverse path carries each slave's response back to the master that holds its grant. All routing uses AND-OR multiplexers, never shared tri-state nets, so two drivers can never contend. Any output with no grant behind it reads as zero. Each master also receives a single flag telling it whether it won any slave.

Top module: `xbar_fixed_prio`

## Requirements
- R1: For every slave column j, `gnt_o[i][j]` is 1 only for the smallest master index i with `req_i[i][j]` = 1. Bit `[i][j]` of `req_i` and `gnt_o` refers to master i and slave j.
- R2: Each slave column has at most one grant bit set. Different columns may hold grants in the same cycle, so several masters can be served at once.
- R3: `s_addr_o[j]` and `s_data_o[j]` equal `m_addr_i[i]` and `m_data_i[i]` of the master i granted slave j. When no master holds slave j, both are zero.
- R4: `m_resp_o[i]` equals `s_resp_i[j]` of a slave j granted to master i. If master i holds several slaves, the lowest slave index is used. If it holds none, the value is zero.
- R5: `granted_o[i]` is 1 exactly when master i holds a grant on at least one slave.
- R6: No grant bit is set where the matching request bit is 0. With all requests at zero, every output is zero.
- R7: The block holds no state. All outputs follow the current inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | NUM_MASTERS*NUM_SLAVES | Request matrix, `[master][slave]` |
| m_addr_i | input | NUM_MASTERS*ADDR_W | Address from each master |
| m_data_i | input | NUM_MASTERS*DATA_W | Data from each master |
| s_resp_i | input | NUM_SLAVES*RESP_W | Response from each slave |
| gnt_o | output | NUM_MASTERS*NUM_SLAVES | Grant matrix, `[master][slave]` |
| granted_o | output | NUM_MASTERS | Master holds at least one grant |
| s_addr_o | output | NUM_SLAVES*ADDR_W | Address routed to each slave |
| s_data_o | output | NUM_SLAVES*DATA_W | Data routed to each slave |
| m_resp_o | output | NUM_MASTERS*RESP_W | Response routed to each master |

## Verification
Two functions can act in the same cycle. Column arbitration can resolve a collision on one slave while other slaves serve different masters. The response path can also pick between several slaves held by one master while forward routing is under way. Both cases are provoked by directed matrices and by random ones, which mix one-hot, empty and multi-hot request rows. Every grant bit, every routed field and every granted flag is compared against a model built from the priority rules.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned DEF_MASTERS = 5;
  localparam int unsigned DEF_SLAVES  = 3;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_RESP_W  = 8;
endpackage

// File: rtl/xbar_prio_pick.sv
// Lowest-index-wins selector: turns any vector into a one-hot-or-zero pick.
module xbar_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] pick_o
);
  always_comb begin
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      pick_o[i] = vec_i[i] & ~hit;
      hit       = hit | vec_i[i];
    end
  end

  always_comb begin
    p_onehot_r2: assert ($onehot0(pick_o));
    p_subset_r6: assert ((pick_o & ~vec_i) == '0);
    p_nonempty_r1: assert ((vec_i == '0) || (pick_o != '0));
  end

  for (genvar g = 1; g < N; g++) begin : g_low
    localparam logic [N-1:0] LOW_MASK = N'((64'd1 << g) - 64'd1);
    always_comb begin
      p_lowest_r1: assert (!(pick_o[g] && ((vec_i & LOW_MASK) != '0)));
    end
  end
endmodule

// File: rtl/xbar_onehot_mux.sv
// AND-OR mux; select must be one-hot or zero, zero select yields zero.
module xbar_onehot_mux #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0]        sel_i,
  input  logic [N-1:0][W-1:0] data_i,
  output logic [W-1:0]        data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++) data_o = data_o | ({W{sel_i[i]}} & data_i[i]);
  end

  always_comb begin
    p_idle_zero_r3: assert ((sel_i != '0) || (data_o == '0));
  end
endmodule

// File: rtl/xbar_fixed_prio.sv
module xbar_fixed_prio
  import xbar_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = DEF_MASTERS,
  parameter int unsigned NUM_SLAVES  = DEF_SLAVES,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned RESP_W      = DEF_RESP_W
) (
  input  logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] req_i,
  input  logic [NUM_MASTERS-1:0][ADDR_W-1:0]     m_addr_i,
  input  logic [NUM_MASTERS-1:0][DATA_W-1:0]     m_data_i,
  input  logic [NUM_SLAVES-1:0][RESP_W-1:0]      s_resp_i,
  output logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] gnt_o,
  output logic [NUM_MASTERS-1:0]                 granted_o,
  output logic [NUM_SLAVES-1:0][ADDR_W-1:0]      s_addr_o,
  output logic [NUM_SLAVES-1:0][DATA_W-1:0]      s_data_o,
  output logic [NUM_MASTERS-1:0][RESP_W-1:0]     m_resp_o
);
  localparam int unsigned FWD_W = ADDR_W + DATA_W;

  logic [NUM_SLAVES-1:0][NUM_MASTERS-1:0] col_req, col_gnt;
  logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] resp_sel;
  logic [NUM_MASTERS-1:0][FWD_W-1:0]      fwd;
  logic [NUM_SLAVES-1:0][FWD_W-1:0]       fwd_out;

  // transpose request matrix into slave columns and grants back into rows
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_tr_m
    for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_tr_s
      assign col_req[s][m] = req_i[m][s];
      assign gnt_o[m][s]   = col_gnt[s][m];
    end
    assign fwd[m] = {m_addr_i[m], m_data_i[m]};
  end

  // per slave: arbitrate column, then route the winner's address and data
  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slv
    xbar_prio_pick #(.N(NUM_MASTERS)) u_arb (
      .vec_i  (col_req[s]),
      .pick_o (col_gnt[s])
    );
    xbar_onehot_mux #(.N(NUM_MASTERS), .W(FWD_W)) u_fwd_mux (
      .sel_i  (col_gnt[s]),
      .data_i (fwd),
      .data_o (fwd_out[s])
    );
    assign s_addr_o[s] = fwd_out[s][FWD_W-1:DATA_W];
    assign s_data_o[s] = fwd_out[s][DATA_W-1:0];
  end

  // per master: lowest held slave drives the response
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    xbar_prio_pick #(.N(NUM_SLAVES)) u_rsel (
      .vec_i  (gnt_o[m]),
      .pick_o (resp_sel[m])
    );
    xbar_onehot_mux #(.N(NUM_SLAVES), .W(RESP_W)) u_resp_mux (
      .sel_i  (resp_sel[m]),
      .data_i (s_resp_i),
      .data_o (m_resp_o[m])
    );
    assign granted_o[m] = |gnt_o[m];
  end

  always_comb begin
    for (int m = 0; m < NUM_MASTERS; m++) begin
      p_resp_idle_r4: assert (granted_o[m] || (m_resp_o[m] == '0));
      p_granted_req_r5: assert (!granted_o[m] || (req_i[m] != '0));
    end
  end
endmodule

// File: tb/xbar_fixed_prio_tb.sv
module xbar_fixed_prio_tb;
  localparam int NM = 5;
  localparam int NS = 3;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RW = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NM-1:0][NS-1:0] req, gnt;
  logic [NM-1:0][AW-1:0] maddr;
  logic [NM-1:0][DW-1:0] mdata;
  logic [NS-1:0][RW-1:0] sresp;
  logic [NM-1:0]         granted;
  logic [NS-1:0][AW-1:0] saddr;
  logic [NS-1:0][DW-1:0] sdata;
  logic [NM-1:0][RW-1:0] mresp;

  xbar_fixed_prio #(.NUM_MASTERS(NM), .NUM_SLAVES(NS), .ADDR_W(AW),
                    .DATA_W(DW), .RESP_W(RW)) u_dut (
    .req_i(req), .m_addr_i(maddr), .m_data_i(mdata), .s_resp_i(sresp),
    .gnt_o(gnt), .granted_o(granted), .s_addr_o(saddr), .s_data_o(sdata),
    .m_resp_o(mresp)
  );

  typedef struct {
    logic [NM-1:0][NS-1:0] req;
    logic [NM-1:0][NS-1:0] gnt;
    logic [NM-1:0]         granted;
    logic [NS-1:0][AW-1:0] addr;
    logic [NS-1:0][DW-1:0] data;
    logic [NM-1:0][RW-1:0] resp;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model from the priority rules
  function automatic exp_t model(input logic [NM-1:0][NS-1:0] r,
                                 input logic [NM-1:0][AW-1:0] a,
                                 input logic [NM-1:0][DW-1:0] d,
                                 input logic [NS-1:0][RW-1:0] rs);
    exp_t e;
    e.req = r; e.gnt = '0; e.granted = '0; e.addr = '0; e.data = '0; e.resp = '0;
    for (int j = 0; j < NS; j++) begin
      for (int i = 0; i < NM; i++) begin
        if (r[i][j]) begin
          e.gnt[i][j] = 1'b1;
          e.addr[j] = a[i];
          e.data[j] = d[i];
          break;
        end
      end
    end
    for (int i = 0; i < NM; i++) begin
      for (int j = NS-1; j >= 0; j--) begin
        if (e.gnt[i][j]) begin
          e.resp[i] = rs[j];
          e.granted[i] = 1'b1;
        end
      end
    end
    return e;
  endfunction

  // driver: apply at negedge, push expectation
  task automatic apply(input logic [NM-1:0][NS-1:0] r);
    @(negedge clk);
    req = r;
    for (int i = 0; i < NM; i++) begin
      maddr[i] = $urandom();
      mdata[i] = $urandom();
    end
    for (int j = 0; j < NS; j++) sresp[j] = RW'($urandom());
    q.push_back(model(req, maddr, mdata, sresp));
  endtask

  // monitor: pop and compare at the following posedge (inputs stable since negedge)
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(gnt == e.gnt, "R1", "grant matrix", 64'(gnt), 64'(e.gnt));
        for (int j = 0; j < NS; j++) begin
          logic [NM-1:0] col;
          for (int i = 0; i < NM; i++) col[i] = gnt[i][j];
          chk($countones(col) <= 1, "R2", "grants per column", 64'(col), 64'(0));
          chk(saddr[j] == e.addr[j], "R3", "slave address", 64'(saddr[j]), 64'(e.addr[j]));
          chk(sdata[j] == e.data[j], "R3", "slave data", 64'(sdata[j]), 64'(e.data[j]));
        end
        chk((gnt & ~e.req) == '0, "R6", "grant without request", 64'(gnt), 64'(e.gnt));
        chk(granted == e.granted, "R5", "granted flags", 64'(granted), 64'(e.granted));
        for (int i = 0; i < NM; i++)
          chk(mresp[i] == e.resp[i], "R4", "master response", 64'(mresp[i]), 64'(e.resp[i]));
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NM-1:0][NS-1:0] r;
    req = '0; maddr = '0; mdata = '0; sresp = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R6: idle state, all outputs zero
    #1;
    chk({gnt, granted, saddr, sdata, mresp} == '0, "R6", "idle outputs", 64'(granted), 64'(0));
    apply('0);
    // R1: every master wants slave 0, master 0 wins
    r = '0; for (int i = 0; i < NM; i++) r[i][0] = 1'b1;
    apply(r);
    // R1: upper masters only collide on the last slave
    r = '0; r[4][NS-1] = 1'b1; r[2][NS-1] = 1'b1; r[3][NS-1] = 1'b1;
    apply(r);
    // R2: distinct slaves served in the same cycle
    r = '0; r[1][0] = 1'b1; r[3][1] = 1'b1; r[4][2] = 1'b1;
    apply(r);
    // R4: one master holds several slaves, lowest slave answers
    r = '0; r[2][1] = 1'b1; r[2][2] = 1'b1; r[0][0] = 1'b0;
    apply(r);
    // R4: master that loses gets zero response
    r = '0; r[0][1] = 1'b1; r[1][1] = 1'b1;
    apply(r);
    // R7: outputs follow new inputs within the same cycle
    @(negedge clk);
    req = '0; req[3][2] = 1'b1; maddr[3] = 32'hCAFE_0003; sresp[2] = 8'h5A;
    #1;
    chk(saddr[2] == 32'hCAFE_0003, "R7", "same-cycle address", 64'(saddr[2]), 64'hCAFE_0003);
    chk(mresp[3] == 8'h5A, "R7", "same-cycle response", 64'(mresp[3]), 64'h5A);
    req[3][2] = 1'b0;
    #1;
    chk(saddr[2] == '0, "R7", "same-cycle release", 64'(saddr[2]), 64'(0));
    // random matrices: mostly one-hot rows, some empty, some multi-hot
    for (int k = 0; k < 2000; k++) begin
      r = '0;
      for (int i = 0; i < NM; i++) begin
        int c;
        c = $urandom_range(0, NS + 1);
        if (c < NS) r[i][c] = 1'b1;
        else if (c == NS + 1) r[i] = NS'($urandom());
      end
      apply(r);
    end
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule